// File: doc/BRIEF.md
# Auto-Scan ADC Channel Sequencer

This block picks the analog multiplexer channel for each conversion on a sixteen-input acquisition front end. A host write loads a 4-bit channel setting. In fixed mode that setting is the only channel ever converted. In scan mode the same setting becomes the last channel of a sweep. Each conversion trigger then moves the live position forward by one, from channel 0 up to the setting, and the position then returns to channel 0.

A controller built as a small state machine tracks the mode. It has two states. FIXED is entered at reset and whenever the scan-enable level is seen low at a clock edge. SCANNING is entered whenever that level is seen high. The transitions are FIXED to SCANNING on scan_en high and SCANNING to FIXED on scan_en low. Every other case holds the state.

A readback byte reports both values. Its low nibble holds the programmed setting. Its high nibble holds the live scan position in SCANNING and reads zero in FIXED. The select changes only after the clock edge that accepts a trigger, so the conversion a trigger starts uses the channel selected before the step.

Top module: `chan_seq_top`

## Requirements
- R1: After reset, mux_sel is 0, rd_byte is 0x00 and the controller is in FIXED.
- R2: In FIXED, mux_sel equals the programmed setting and rd_byte[7:4] is 0. Conversion triggers change neither output.
- R3: A write (wr_en high at a clock edge) stores wr_data[3:0] as the setting, which appears on rd_byte[3:0] from the next cycle on. wr_data[7:4] is ignored.
- R4: The mode follows scan_en with one cycle of delay: scan_en sampled high at an edge selects SCANNING from the next cycle, and scan_en sampled low selects FIXED. A sweep that is entered starts at channel 0.
- R5: In SCANNING, mux_sel and rd_byte[7:4] both equal the live position. A trigger sampled at an edge, with the position below the setting, raises the position by one from the next cycle.
- R6: In SCANNING, a trigger sampled while the position equals the setting returns the position to 0.
- R7: In SCANNING with the setting at 0, the position stays 0 under any number of triggers.
- R8: A write returns the position to 0 in the next cycle, even when a trigger is sampled at the same edge.
- R9: Leaving SCANNING returns mux_sel to the setting. A later sweep starts again at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Channel register write strobe |
| wr_data | input | 8 | Write data; bits 3:0 are the setting |
| scan_en | input | 1 | Mode level: 1 = scan, 0 = fixed |
| conv_trig | input | 1 | One-cycle conversion trigger |
| mux_sel | output | 4 | Multiplexer channel select |
| rd_byte | output | 8 | {position or 0, setting} |

## Verification
A wrong position shows on both mux_sel and rd_byte[7:4] in the first cycle after the bad edge, because both outputs are read straight from the position register. A wrong wrap bound, or a missed reset on write, shows as a repeated or skipped channel within one sweep. A wrong state shows in the cycle after the scan_en change, either as the high nibble failing to read zero or as the select ignoring the setting. For that reason the expected values are compared in every cycle, not only at the ends of a sweep.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
    typedef enum logic [0:0] {
        ST_FIXED    = 1'b0,
        ST_SCANNING = 1'b1
    } seq_state_t;
endpackage

// File: rtl/chan_cfg_reg.sv
module chan_cfg_reg #(
    parameter int SEL_W = 4,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic [SEL_W-1:0] setting
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setting <= '0;
        end else if (wr_en) begin
            setting <= wr_data[SEL_W-1:0];
        end
    end

    // R3
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> setting == $past(wr_data[SEL_W-1:0]));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(setting));
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import chan_seq_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             scan_en,
    input  logic             conv_trig,
    input  logic [SEL_W-1:0] end_ch,
    output seq_state_t       state,
    output logic [SEL_W-1:0] pos
);
    seq_state_t       state_nx;
    logic [SEL_W-1:0] pos_nx;
    logic             at_end;

    assign at_end = (pos == end_ch);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FIXED:    if (scan_en)  state_nx = ST_SCANNING;
            ST_SCANNING: if (!scan_en) state_nx = ST_FIXED;
            default:     state_nx = ST_FIXED;
        endcase
    end

    always_comb begin
        pos_nx = pos;
        unique case (state)
            ST_FIXED: pos_nx = '0;
            ST_SCANNING: begin
                if (conv_trig) begin
                    pos_nx = at_end ? '0 : SEL_W'(pos + 1'b1);
                end
            end
            default: pos_nx = '0;
        endcase
        if (wr_en) begin
            pos_nx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FIXED;
            pos   <= '0;
        end else begin
            state <= state_nx;
            pos   <= pos_nx;
        end
    end

    // R5
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= end_ch);

    // R5
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCANNING && conv_trig && !wr_en && pos != end_ch)
        |=> pos == SEL_W'($past(pos) + 1'b1));

    // R6
    pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCANNING && conv_trig && pos == end_ch) |=> pos == '0);

    // R8
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pos == '0);

    // R4
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> state == ST_SCANNING);

    // R4
    fixed_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIXED) |=> pos == '0);
endmodule

// File: rtl/readback_mux.sv
module readback_mux
    import chan_seq_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  seq_state_t         state,
    input  logic [SEL_W-1:0]   setting,
    input  logic [SEL_W-1:0]   pos,
    output logic [SEL_W-1:0]   mux_sel,
    output logic [2*SEL_W-1:0] rd_byte
);
    logic [SEL_W-1:0] hi_nib;

    always_comb begin
        unique case (state)
            ST_SCANNING: begin
                mux_sel = pos;
                hi_nib  = pos;
            end
            default: begin
                mux_sel = setting;
                hi_nib  = '0;
            end
        endcase
        rd_byte = {hi_nib, setting};
    end
endmodule

// File: rtl/chan_seq_top.sv
module chan_seq_top
    import chan_seq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int BUS_W  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       scan_en,
    input  logic       conv_trig,
    output logic [3:0] mux_sel,
    output logic [7:0] rd_byte
);
    localparam int SEL_W = $clog2(NUM_CH);

    seq_state_t       state;
    logic [SEL_W-1:0] setting;
    logic [SEL_W-1:0] pos;

    chan_cfg_reg #(.SEL_W(SEL_W), .BUS_W(BUS_W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .setting (setting)
    );

    scan_ctrl #(.SEL_W(SEL_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .scan_en   (scan_en),
        .conv_trig (conv_trig),
        .end_ch    (setting),
        .state     (state),
        .pos       (pos)
    );

    readback_mux #(.SEL_W(SEL_W)) rb_i (
        .state   (state),
        .setting (setting),
        .pos     (pos),
        .mux_sel (mux_sel),
        .rd_byte (rd_byte)
    );

    // R2
    fixed_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIXED && !wr_en && !scan_en) |=> $stable(mux_sel));

    // R2
    fixed_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en) |=> rd_byte[7:4] == 4'h0);
endmodule

// File: tb/chan_seq_top_tb_top.sv
`timescale 1ns/1ps
module chan_seq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       scan_en = 1'b0;
    logic       conv_trig = 1'b0;
    logic [3:0] mux_sel;
    logic [7:0] rd_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] m_set = 4'h0;
    logic [3:0] m_pos = 4'h0;
    bit         m_scan = 1'b0;

    always #2 clk = ~clk;

    chan_seq_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .scan_en   (scan_en),
        .conv_trig (conv_trig),
        .mux_sel   (mux_sel),
        .rd_byte   (rd_byte)
    );

    function automatic logic [3:0] exp_sel();
        return m_scan ? m_pos : m_set;
    endfunction

    function automatic logic [7:0] exp_rd();
        return {(m_scan ? m_pos : 4'h0), m_set};
    endfunction

    task automatic check_out(input string tag);
        checks++;
        if (mux_sel !== exp_sel() || rd_byte !== exp_rd()) begin
            errors++;
            $display("FAIL %s: mux_sel=%h rd_byte=%h expected mux_sel=%h rd_byte=%h",
                     tag, mux_sel, rd_byte, exp_sel(), exp_rd());
        end
    endtask

    task automatic step(input bit wr, input logic [7:0] d, input bit se,
                        input bit tr, input string tag);
        logic [3:0] nx_pos;
        wr_en = wr; wr_data = d; scan_en = se; conv_trig = tr;
        @(posedge clk);
        if (wr) nx_pos = 4'h0;
        else if (!m_scan) nx_pos = 4'h0;
        else if (tr) nx_pos = (m_pos == m_set) ? 4'h0 : m_pos + 4'h1;
        else nx_pos = m_pos;
        if (wr) m_set = d[3:0];
        m_pos = nx_pos;
        m_scan = se;
        @(negedge clk);
        wr_en = 1'b0; conv_trig = 1'b0;
        check_out(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC0_0A11));
        repeat (3) @(negedge clk);
        check_out("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after release");

        // R2 and R3: fixed channel, upper write bits ignored
        step(1, 8'hA7, 0, 0, "R3 write low nibble");
        step(0, 8'h00, 0, 1, "R2 trigger in fixed");
        step(0, 8'h00, 0, 1, "R2 trigger in fixed again");
        step(1, 8'hF3, 0, 1, "R3 upper bits ignored");

        // R4, R5, R6: sweep up to 3 and wrap
        step(0, 8'h00, 1, 1, "R4 enter scan, trigger not counted");
        step(0, 8'h00, 1, 0, "R4 sweep starts at 0");
        for (int i = 0; i < 9; i++) step(0, 8'h00, 1, 1, "R5 R6 sweep step");
        step(0, 8'h00, 1, 0, "R5 hold without trigger");

        // R8: write with trigger in the same cycle
        step(0, 8'h00, 1, 1, "R5 advance before write");
        step(1, 8'h05, 1, 1, "R8 write beats trigger");
        for (int i = 0; i < 7; i++) step(0, 8'h00, 1, 1, "R6 wrap at 5");

        // R7: end channel 0
        step(1, 8'h00, 1, 0, "R7 set end 0");
        for (int i = 0; i < 4; i++) step(0, 8'h00, 1, 1, "R7 stays 0");

        // R6: full range end 15
        step(1, 8'h0F, 1, 0, "R6 set end 15");
        for (int i = 0; i < 17; i++) step(0, 8'h00, 1, 1, "R6 full sweep");

        // R9: leave and re-enter
        step(0, 8'h00, 0, 1, "R9 leave scan");
        step(0, 8'h00, 0, 1, "R9 fixed after leave");
        step(0, 8'h00, 1, 0, "R9 re-enter");
        step(0, 8'h00, 1, 0, "R9 sweep restarts at 0");

        // mixed random stimulus
        for (int i = 0; i < 3000; i++) begin
            bit wr, se, tr;
            logic [7:0] d;
            wr = ($urandom_range(0, 15) == 0);
            se = ($urandom_range(0, 19) != 0);
            tr = ($urandom_range(0, 2) != 0);
            d  = 8'($urandom_range(0, 255));
            step(wr, d, se, tr, "R2 R4 R5 R6 R8 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule